// File: doc/BRIEF.md
# Read-Path Automatic Power-Down Controller

This block sits beside the storage array of an asynchronous parallel memory. It drives the data-bus output enable and reports a power state. The chip-select, output-select and write-strobe inputs (all active low) and the address bus are sampled in the system clock domain. The output enable follows the chip-select and output-select inputs with no clock delay.

A read counts as complete once the read controls and the address have stayed unchanged for a set number of clock edges, equal to the access time. The block then reports a near-standby low-power state. The data outputs stay driven during that state. Any change on the address or on a control input returns the block to the active state in the same cycle, before the next clock edge, so no access time is lost. Chip-select high always reports full standby.

After reset with chip-select held low, the automatic low-power state is blocked. It stays blocked until the block samples an address change or chip-select high. Toggling the output-select input alone does not lift this block.

Top module: `apd_read_ctrl`

## Requirements
- R1: `dq_oe` is 1 in the same cycle, without waiting for a clock edge, exactly when `ce_n` and `oe_n` are both 0; otherwise it is 0 (data bus high impedance).
- R2: While `ce_n` is 1, `pwr_state` is 2'b10 (standby), whatever the other inputs or the history.
- R3: With `ce_n`=0, `oe_n`=0 and `we_n`=1, `pwr_state` becomes 2'b01 (low power) only after the inputs have stayed unchanged for ACCESS_CYCLES rising edges following the edge that first sampled them changed; one edge earlier it is still 2'b00.
- R4: A change of any address bit, even a single one, takes `pwr_state` from 2'b01 to 2'b00 in the same cycle as the change.
- R5: A change of `ce_n`, `oe_n` or `we_n` likewise leaves 2'b01 in the same cycle, and a new stable window is needed before re-entry.
- R6: While `pwr_state` is 2'b01, `dq_oe` stays 1.
- R7: After reset with `ce_n` held 0, `pwr_state` never becomes 2'b01 until an address change or `ce_n`=1 has been sampled; toggling `oe_n` does not lift this.
- R8: With `ce_n`=0 and no read in progress (`oe_n`=1 or `we_n`=0), `pwr_state` is 2'b00, however long the inputs are held.
- R9: During reset, `pwr_state` is 2'b10 if `ce_n` is 1 and 2'b00 otherwise, and the settle count starts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output select, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | AW | Word address |
| dq_oe | output | 1 | Data-bus output enable |
| pwr_state | output | 2 | 00 active, 01 automatic low power, 10 standby |

## Verification
The stable-read window is exercised three ways, each in its own sequence.
- A fresh read after chip-select falls.
- A single-bit address step.
- An output-select pulse.

Each is checked one cycle before entry and at entry, which separates an off-by-one window from a correct one. Write cycles and output-select-high holds confirm that holding inputs steady without a read never lowers power. Two reset sequences with chip-select held low separate the arming events (an address step, chip-select high) from output-select toggling, which must leave the block unarmed.

// File: rtl/apd_pkg.sv
package apd_pkg;
   typedef enum logic [1:0] {
      PWR_ACTIVE = 2'b00,
      PWR_LOW    = 2'b01,
      PWR_STBY   = 2'b10
   } pwr_e;
endpackage

// File: rtl/apd_change_detect.sv
// Keeps the previously sampled inputs and flags any difference with the
// present ones combinationally, so wake-up costs no clock cycle.
module apd_change_detect #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic [AW-1:0] addr,
   output logic          any_evt,
   output logic          addr_evt
);
   localparam int SW = AW + 3;

   logic [SW-1:0] now_vec, prev_vec;
   logic          seen_q;

   assign now_vec = {ce_n, oe_n, we_n, addr};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_vec <= '0;
         seen_q   <= 1'b0;
      end else begin
         prev_vec <= now_vec;
         seen_q   <= 1'b1;
      end
   end

   assign addr_evt = seen_q && (now_vec[AW-1:0] != prev_vec[AW-1:0]);
   assign any_evt  = seen_q && (now_vec != prev_vec);
endmodule

// File: rtl/apd_settle_timer.sv
// Counts clock edges during which a read is held without any input change.
module apd_settle_timer #(
   parameter int ACCESS_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic done
);
   localparam int CW = $clog2(ACCESS_CYCLES + 1);
   localparam logic [CW-1:0] LIMIT = CW'(ACCESS_CYCLES);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!run || clr)    cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
   end

   assign done = (cnt_q == LIMIT);
endmodule

// File: rtl/apd_arm_tracker.sv
// Power-up guard: low-power entry is allowed only once an address change
// or a deselect has been sampled since reset.
module apd_arm_tracker (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic addr_evt,
   output logic armed
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 armed <= 1'b0;
      else if (ce_n || addr_evt)  armed <= 1'b1;
   end
endmodule

// File: rtl/apd_read_ctrl.sv
module apd_read_ctrl #(
   parameter int AW            = 16,
   parameter int ACCESS_CYCLES = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic [AW-1:0] addr,
   output logic          dq_oe,
   output logic [1:0]    pwr_state
);
   import apd_pkg::*;

   generate
      if (AW < 1) begin : g_bad_aw
         $error("apd_read_ctrl: AW must be at least 1");
      end
      if (ACCESS_CYCLES < 1) begin : g_bad_acc
         $error("apd_read_ctrl: ACCESS_CYCLES must be at least 1");
      end
   endgenerate

   logic rd_req, any_evt, addr_evt, settled, armed;
   pwr_e st;

   assign rd_req = !ce_n && !oe_n && we_n;

   apd_change_detect #(.AW(AW)) u_det (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .any_evt(any_evt), .addr_evt(addr_evt)
   );

   apd_settle_timer #(.ACCESS_CYCLES(ACCESS_CYCLES)) u_tmr (
      .clk(clk), .rst_n(rst_n), .run(rd_req), .clr(any_evt), .done(settled)
   );

   apd_arm_tracker u_arm (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .addr_evt(addr_evt), .armed(armed)
   );

   always_comb begin
      if (ce_n)                                   st = PWR_STBY;
      else if (rd_req && settled && armed && !any_evt) st = PWR_LOW;
      else                                        st = PWR_ACTIVE;
   end

   assign pwr_state = st;
   assign dq_oe     = !ce_n && !oe_n;
endmodule

// File: rtl/apd_read_ctrl_chk.sv
module apd_read_ctrl_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ce_n,
   input logic          oe_n,
   input logic          we_n,
   input logic [AW-1:0] addr,
   input logic          dq_oe,
   input logic [1:0]    pwr_state
);
   logic          obs_armed;
   logic          obs_seen;
   logic [AW-1:0] obs_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         obs_armed <= 1'b0;
         obs_seen  <= 1'b0;
         obs_addr  <= '0;
      end else begin
         obs_seen  <= 1'b1;
         obs_addr  <= addr;
         if (ce_n || (obs_seen && addr != obs_addr)) obs_armed <= 1'b1;
      end
   end

   a_r1_hiz_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n || oe_n) |-> !dq_oe);
   a_r2_standby_priority: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |-> (pwr_state == 2'b10));
   a_r3_low_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'b01) |-> (!ce_n && !oe_n && we_n));
   a_r4_addr_wakes: assert property (@(posedge clk) disable iff (!rst_n)
      (obs_seen && addr != obs_addr) |-> (pwr_state != 2'b01));
   a_r5_ctrl_wakes: assert property (@(posedge clk) disable iff (!rst_n)
      (obs_seen && !$stable({ce_n, oe_n, we_n})) |-> (pwr_state != 2'b01));
   a_r6_low_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'b01) |-> dq_oe);
   a_r7_powerup_guard: assert property (@(posedge clk) disable iff (!rst_n)
      !obs_armed |-> (pwr_state != 2'b01));
   a_r8_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_state != 2'b11);
endmodule

bind apd_read_ctrl apd_read_ctrl_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
   .addr(addr), .dq_oe(dq_oe), .pwr_state(pwr_state)
);

// File: tb/sim_apd_read_ctrl.sv
module sim_apd_read_ctrl;
   localparam int AW  = 16;
   localparam int ACC = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic          dq_oe;
   logic [1:0]    pwr_state;

   int n_chk = 0;
   int n_fail = 0;
   bit done_flag = 1'b0;

   always #4 clk = ~clk;

   apd_read_ctrl #(.AW(AW), .ACCESS_CYCLES(ACC)) u0 (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .dq_oe(dq_oe), .pwr_state(pwr_state)
   );

   // {req[3:0], ce_n, oe_n, we_n, addr[15:0], exp_oe, exp_state[1:0]}
   localparam logic [25:0] VEC [0:24] = '{
      {4'd1, 3'b001, 16'h0010, 1'b1, 2'b00}, // R1 read starts
      {4'd3, 3'b001, 16'h0010, 1'b1, 2'b00},
      {4'd3, 3'b001, 16'h0010, 1'b1, 2'b00},
      {4'd3, 3'b001, 16'h0010, 1'b1, 2'b00},
      {4'd3, 3'b001, 16'h0010, 1'b1, 2'b00}, // R3 one edge short
      {4'd6, 3'b001, 16'h0010, 1'b1, 2'b01}, // R3 / R6 low power, data kept
      {4'd6, 3'b001, 16'h0010, 1'b1, 2'b01},
      {4'd4, 3'b001, 16'h0011, 1'b1, 2'b00}, // R4 single-bit wake
      {4'd3, 3'b001, 16'h0011, 1'b1, 2'b00},
      {4'd3, 3'b001, 16'h0011, 1'b1, 2'b00},
      {4'd3, 3'b001, 16'h0011, 1'b1, 2'b00},
      {4'd3, 3'b001, 16'h0011, 1'b1, 2'b00},
      {4'd3, 3'b001, 16'h0011, 1'b1, 2'b01},
      {4'd5, 3'b011, 16'h0011, 1'b0, 2'b00}, // R5 oe_n rises
      {4'd8, 3'b011, 16'h0011, 1'b0, 2'b00}, // R8 no read
      {4'd5, 3'b001, 16'h0011, 1'b1, 2'b00}, // R5 oe_n falls
      {4'd5, 3'b001, 16'h0011, 1'b1, 2'b00},
      {4'd5, 3'b001, 16'h0011, 1'b1, 2'b00},
      {4'd5, 3'b001, 16'h0011, 1'b1, 2'b00},
      {4'd5, 3'b001, 16'h0011, 1'b1, 2'b00},
      {4'd5, 3'b001, 16'h0011, 1'b1, 2'b01},
      {4'd2, 3'b101, 16'h0011, 1'b0, 2'b10}, // R2 standby
      {4'd2, 3'b111, 16'h0011, 1'b0, 2'b10},
      {4'd8, 3'b010, 16'h0011, 1'b0, 2'b00}, // R8 write held
      {4'd8, 3'b010, 16'h0011, 1'b0, 2'b00}
   };

   task automatic chk(input int req, input logic e_oe, input logic [1:0] e_st);
      n_chk++;
      if (dq_oe !== e_oe || pwr_state !== e_st) begin
         n_fail++;
         $display("FAIL R%0d: dq_oe=%b pwr_state=%b, expected dq_oe=%b pwr_state=%b",
                  req, dq_oe, pwr_state, e_oe, e_st);
      end
   endtask

   task automatic do_reset(input logic c, input logic o, input logic [AW-1:0] a);
      @(negedge clk);
      rst_n = 1'b0; ce_n = c; oe_n = o; we_n = 1'b1; addr = a;
      repeat (2) @(negedge clk);
      #1;
      // R9 reset state
      chk(9, !c && !o, c ? 2'b10 : 2'b00);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(8 * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      // Vector walk, armed by deselect during reset
      do_reset(1'b1, 1'b1, 16'h0000);
      for (int k = 0; k < 25; k++) begin
         @(negedge clk);
         {ce_n, oe_n, we_n, addr} = VEC[k][21:3];
         #1;
         chk(int'(VEC[k][25:22]), VEC[k][2], VEC[k][1:0]);
      end

      // R7: power-up with chip select low, oe toggling does not arm
      do_reset(1'b0, 1'b0, 16'h0100);
      repeat (10) @(negedge clk);
      #1 chk(7, 1'b1, 2'b00);
      @(negedge clk) oe_n = 1'b1;
      #1 chk(1, 1'b0, 2'b00); // R1 oe high gives high impedance
      @(negedge clk) oe_n = 1'b0;
      repeat (10) @(negedge clk);
      #1 chk(7, 1'b1, 2'b00);
      // address step arms it; R3 window boundary
      @(negedge clk) addr = 16'h0101;
      repeat (4) @(negedge clk);
      #1 chk(3, 1'b1, 2'b00);
      @(negedge clk);
      #1 chk(7, 1'b1, 2'b01);

      // R7: power-up with chip select low, deselect arms it
      do_reset(1'b0, 1'b0, 16'h0200);
      repeat (8) @(negedge clk);
      #1 chk(7, 1'b1, 2'b00);
      @(negedge clk) ce_n = 1'b1;
      #1 chk(2, 1'b0, 2'b10);
      @(negedge clk) ce_n = 1'b0;
      #1 chk(5, 1'b1, 2'b00);
      repeat (5) @(negedge clk);
      #1 chk(7, 1'b1, 2'b01);
      // R5 we_n pulse wakes, then needs a fresh window
      @(negedge clk) we_n = 1'b0;
      #1 chk(5, 1'b1, 2'b00);
      @(negedge clk) we_n = 1'b1;
      repeat (4) @(negedge clk);
      #1 chk(5, 1'b1, 2'b00);
      @(negedge clk);
      #1 chk(5, 1'b1, 2'b01);

      finish_run();
   end
endmodule